// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Tick Generation

The block is a 16-bit up-counter. A companion 16-bit register pair serves either as the reload value or as the capture destination, and an 8-bit control register selects the mode. The counter advances on an internal tick enable or on falling edges of a count pin. When it wraps from FFFFh it can reload itself from the register pair. Falling edges on a separate trigger pin can reload the counter or snapshot it into the pair. Snapshots do not disturb counting, so software can measure the interval between two events without stopping the timer.

When either baud select bit is set, each wrap drives a one-cycle tick on the receive or the transmit baud output, or on both. A serial port can use these ticks as its bit-rate clock. In this mode the overflow flag stays clear and the reload on wrap always happens. Two sticky flags mark overflow and trigger events. An interrupt output combines these flags with a timer enable and a global enable.

All registers sit behind a plain byte-wide write strobe with a combinational read. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. Every pin is plain control or status.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, all five registers read 00h, and `irq`, `rx_baud_tick` and `tx_baud_tick` are 0.
- R2: Register map on `reg_addr`:
  - 0 is control. Bit 7 is the overflow flag, bit 6 the trigger flag, bit 5 the receive baud select, bit 4 the transmit baud select, bit 3 the trigger enable, bit 2 run, bit 1 the count source (1 means pin) and bit 0 the capture mode.
  - 1 is the count low byte and 2 the count high byte.
  - 3 is the capture/reload low byte and 4 the capture/reload high byte.

  A write with `reg_wr`=1 takes effect at the clock edge, and all eight control bits are writable. `reg_rdata` shows the addressed register combinationally. Addresses 5 to 7 read 00h and writes to them change nothing.
- R3: The counter advances by one per enabled event, and only while run is 1.
  - With count source 0, an enabled event is a cycle with `tick_en`=1.
  - With count source 1, an enabled event is a falling edge on `cnt_pin`, after a two-flop synchronizer. `tick_en` is then ignored.
- R4: With capture mode 0, an increment from FFFFh loads the counter with the capture/reload pair.
- R5: With capture mode 0 and trigger enable 1, a synchronized falling edge on `trig_pin` loads the counter from the pair and sets the trigger flag. With trigger enable 0, such an edge has no effect.
- R6: With capture mode 1 and trigger enable 1, a trigger falling edge copies the count, as it was before that cycle's increment, into the pair. It also sets the trigger flag. Counting carries on without a pause.
- R7: With both baud selects 0, an increment from FFFFh sets the overflow flag. This holds in either capture mode, and with capture mode 1 the counter wraps to 0000h.
- R8: With either baud select set, a wrap leaves the overflow flag unchanged. The wrap reloads the counter even when capture mode is 1. In the cycle after each wrap, `rx_baud_tick` is 1 if receive select is set and `tx_baud_tick` is 1 if transmit select is set.
- R9: `irq` is 1 exactly when (overflow flag or trigger flag) is 1, `tmr_ie` is 1 and `glb_ie` is 1.
- R10: The flags clear only through a software write to control. A hardware set in the same cycle as a software clear wins.
- R11: A software write to a count byte overrides the increment, reload, capture-free wrap and the overflow flag that the same cycle would have caused. The other count byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tick_en | input | 1 | Internal count enable |
| cnt_pin | input | 1 | External count pin, counted on falling edges |
| trig_pin | input | 1 | External trigger pin, acting on falling edges |
| tmr_ie | input | 1 | Timer interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| rx_baud_tick | output | 1 | Receive baud tick, one pulse per wrap |
| tx_baud_tick | output | 1 | Transmit baud tick, one pulse per wrap |

## Verification
The assertions check these rules in every cycle:
- a reload lands the old pair value in the counter;
- a plain increment adds exactly one;
- a capture copies the prior count;
- a wrap outside baud mode sets the overflow flag, while a wrap in baud mode leaves it alone;
- a flag never falls without a control write;
- a single-byte count write leaves the other byte alone;
- the interrupt never fires with an enable low.

The bench scenarios show what these local rules cannot:
- sweeps of reload values and tick counts against an arithmetic model;
- the baud tick totals per select;
- the pin edge latency, seen in the exact captured value;
- the outcomes when writes collide with counter events.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd4;

  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic pin_src;
    logic cap_mode;
  } ctrl_t;
endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  // sh[STAGES-1:0] is the synchronizer; sh[STAGES] holds the previous sample
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin_i};
  end

  assign fall_o = sh[STAGES] & ~sh[STAGES-1];

  // R3: a falling edge is reported for one cycle only
  a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/crt_counter.sv
module crt_counter
  import crt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W/BYTE_W-1:0] cnt_wr,
  input  logic [CNT_W/BYTE_W-1:0] cap_wr,
  input  logic [BYTE_W-1:0]      wdata,
  input  logic                   inc,
  input  logic                   ovf_rl_en,
  input  logic                   ext_reload,
  input  logic                   ext_capture,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [CNT_W-1:0]       cap_o,
  output logic                   ovf_o
);
  localparam int NB = CNT_W / BYTE_W;

  logic sw_cnt;
  logic do_reload;

  assign sw_cnt    = |cnt_wr;
  assign ovf_o     = inc & (&cnt_o) & ~sw_cnt;
  assign do_reload = (ovf_o & ovf_rl_en) | ext_reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (sw_cnt) begin
      for (int b = 0; b < NB; b++)
        if (cnt_wr[b]) cnt_o[b*BYTE_W +: BYTE_W] <= wdata;
    end else if (do_reload) begin
      cnt_o <= cap_o;
    end else if (inc) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o <= '0;
    end else if (|cap_wr) begin
      for (int b = 0; b < NB; b++)
        if (cap_wr[b]) cap_o[b*BYTE_W +: BYTE_W] <= wdata;
    end else if (ext_capture) begin
      cap_o <= cnt_o;
    end
  end

  // R4 / R5: a reload lands the previous pair value in the counter
  a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (do_reload && !sw_cnt) |=> (cnt_o == $past(cap_o)));

  // R3: a plain increment adds exactly one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !do_reload && !sw_cnt) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  // R6: a capture stores the count seen before the edge
  a_r6_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_capture && cap_wr == '0) |=> (cap_o == $past(cnt_o)));

  // R11: writing only the low count byte leaves the high byte alone
  a_r11_other_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr == 2'b01) |=> (cnt_o[CNT_W-1 -: BYTE_W] == $past(cnt_o[CNT_W-1 -: BYTE_W])));
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  ctrl_t wdata,
  input  logic  ovf,
  input  logic  ext_evt,
  input  logic  tmr_ie,
  input  logic  glb_ie,
  output ctrl_t ctrl_o,
  output logic  irq_o,
  output logic  rx_tick_o,
  output logic  tx_tick_o
);
  ctrl_t nxt;
  logic  baud;

  assign baud = ctrl_o.rx_sel | ctrl_o.tx_sel;

  always_comb begin
    nxt = ctrl_o;
    if (wr) nxt = wdata;
    if (ovf && !baud) nxt.ovf_flag = 1'b1;
    if (ext_evt) nxt.ext_flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o    <= '0;
      rx_tick_o <= 1'b0;
      tx_tick_o <= 1'b0;
    end else begin
      ctrl_o    <= nxt;
      rx_tick_o <= ovf & ctrl_o.rx_sel;
      tx_tick_o <= ovf & ctrl_o.tx_sel;
    end
  end

  assign irq_o = (ctrl_o.ovf_flag | ctrl_o.ext_flag) & tmr_ie & glb_ie;

  // R7: a wrap outside baud mode raises the overflow flag
  a_r7_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !baud) |=> ctrl_o.ovf_flag);

  // R8: a wrap in baud mode does not touch the overflow flag
  a_r8_baud_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && baud && !wr) |=> $stable(ctrl_o.ovf_flag));

  // R10: flags fall only after a control write
  a_r10_ovf_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !$fell(ctrl_o.ovf_flag));
  a_r10_ext_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !$fell(ctrl_o.ext_flag));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              tick_en,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              tmr_ie,
  input  logic              glb_ie,
  output logic              irq,
  output logic              rx_baud_tick,
  output logic              tx_baud_tick
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int NPIN  = 2;

  logic [NPIN-1:0] pins;
  logic [NPIN-1:0] falls;
  logic            cnt_fall, trig_fall;

  assign pins = {trig_pin, cnt_pin};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pins[p]),
      .fall_o (falls[p])
    );
  end

  assign cnt_fall  = falls[0];
  assign trig_fall = falls[1];

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, cap;
  logic             ovf, inc, ext_evt;
  logic             wr_ctrl;
  logic [1:0]       cnt_wr, cap_wr;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign cnt_wr  = {reg_wr && (reg_addr == A_CNT_HI), reg_wr && (reg_addr == A_CNT_LO)};
  assign cap_wr  = {reg_wr && (reg_addr == A_CAP_HI), reg_wr && (reg_addr == A_CAP_LO)};

  assign inc     = ctrl.run & (ctrl.pin_src ? cnt_fall : tick_en);
  assign ext_evt = ctrl.ext_en & trig_fall;

  crt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_wr      (cnt_wr),
    .cap_wr      (cap_wr),
    .wdata       (reg_wdata),
    .inc         (inc),
    .ovf_rl_en   (~ctrl.cap_mode | ctrl.rx_sel | ctrl.tx_sel),
    .ext_reload  (ext_evt & ~ctrl.cap_mode),
    .ext_capture (ext_evt & ctrl.cap_mode),
    .cnt_o       (cnt),
    .cap_o       (cap),
    .ovf_o       (ovf)
  );

  crt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_ctrl),
    .wdata     (ctrl_t'(reg_wdata)),
    .ovf       (ovf),
    .ext_evt   (ext_evt),
    .tmr_ie    (tmr_ie),
    .glb_ie    (glb_ie),
    .ctrl_o    (ctrl),
    .irq_o     (irq),
    .rx_tick_o (rx_baud_tick),
    .tx_tick_o (tx_baud_tick)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = ctrl;
      A_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
      A_CNT_HI: reg_rdata = cnt[CNT_W-1 -: BYTE_W];
      A_CAP_LO: reg_rdata = cap[BYTE_W-1:0];
      A_CAP_HI: reg_rdata = cap[CNT_W-1 -: BYTE_W];
      default:  reg_rdata = '0;
    endcase
  end

  // R9: no interrupt while either enable is low
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tmr_ie && glb_ie));

  // R5: with the trigger disabled, a trigger edge leaves the flag low
  a_r5_trig_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fall && !ctrl.ext_en && !ctrl.ext_flag && !wr_ctrl) |=> !ctrl.ext_flag);
endmodule

// File: tb/sim_cap_reload_timer.sv
module sim_cap_reload_timer;
  import crt_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tick_en = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       tmr_ie = 1'b0;
  logic       glb_ie = 1'b0;
  logic       irq, rx_baud_tick, tx_baud_tick;

  cap_reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .tmr_ie(tmr_ie), .glb_ie(glb_ie),
    .irq(irq), .rx_baud_tick(rx_baud_tick), .tx_baud_tick(tx_baud_tick)
  );

  localparam logic [7:0] C_TF = 8'h80, C_EXF = 8'h40, C_RX = 8'h20, C_TX = 8'h10;
  localparam logic [7:0] C_EXEN = 8'h08, C_RUN = 8'h04, C_PIN = 8'h02, C_CAP = 8'h01;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  int  rx_seen = 0;
  int  tx_seen = 0;

  always @(negedge clk) begin
    if (rx_baud_tick) rx_seen++;
    if (tx_baud_tick) tx_seen++;
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] h, l;
    rd(lo + 3'd1, h);
    rd(lo, l);
    v = {h, l};
  endtask

  task automatic set16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 3'd1, v[15:8]);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_pin = 1'b0;
    repeat (4) @(negedge clk); trig_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_cnt();
    @(negedge clk); cnt_pin = 1'b0;
    repeat (3) @(negedge clk); cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] step_rl(input logic [15:0] e, input logic [15:0] r);
    return (e == 16'hFFFF) ? r : e + 16'd1;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, e;
    int base_rx, base_tx;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      chk("R1 reset register", {8'h00, b}, 16'h0000);
    end
    chk("R1 reset outputs", {13'd0, irq, rx_baud_tick, tx_baud_tick}, 16'h0000);

    // R2: control register sweep, all bits writable
    for (int c = 0; c < 256; c++) begin
      wr(A_CTRL, 8'(c));
      rd(A_CTRL, b);
      chk("R2 control readback", {8'h00, b}, 16'(c));
    end
    wr(A_CTRL, 8'h00);
    set16(A_CNT_LO, 16'hA55A);
    set16(A_CAP_LO, 16'h3CC3);
    rd16(A_CNT_LO, v); chk("R2 count readback", v, 16'hA55A);
    rd16(A_CAP_LO, v); chk("R2 capture readback", v, 16'h3CC3);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      rd(3'(a), b);
      chk("R2 unmapped reads zero", {8'h00, b}, 16'h0000);
    end
    rd16(A_CNT_LO, v); chk("R2 unmapped write no effect on count", v, 16'hA55A);
    rd16(A_CAP_LO, v); chk("R2 unmapped write no effect on pair", v, 16'h3CC3);
    rd(A_CTRL, b);     chk("R2 unmapped write no effect on control", {8'h00, b}, 16'h0000);

    // R3: internal ticks, several counts, and no counting while stopped
    for (int n = 1; n < 40; n += 7) begin
      set16(A_CNT_LO, 16'h1200);
      run_ticks(n);
      settle();
      rd16(A_CNT_LO, v); chk("R3 stopped ignores ticks", v, 16'h1200);
      wr(A_CTRL, C_RUN);
      run_ticks(n);
      settle();
      rd16(A_CNT_LO, v); chk("R3 tick count", v, 16'h1200 + 16'(n));
      wr(A_CTRL, 8'h00);
    end

    // R3: pin source counts falling edges, tick_en ignored
    set16(A_CNT_LO, 16'h0010);
    wr(A_CTRL, C_PIN);
    repeat (3) pulse_cnt();
    rd16(A_CNT_LO, v); chk("R3 pin mode stopped", v, 16'h0010);
    wr(A_CTRL, C_RUN | C_PIN);
    tick_en = 1'b1;
    repeat (5) pulse_cnt();
    tick_en = 1'b0;
    settle();
    rd16(A_CNT_LO, v); chk("R3 pin edges counted", v, 16'h0015);
    wr(A_CTRL, 8'h00);

    // R4 / R7: overflow reload sweep
    for (int ri = 0; ri < 4; ri++) begin
      for (int k = 0; k < 3; k += 2) begin
        for (int m = 0; m < 4; m += 3) begin
          logic [15:0] r;
          int ovfs;
          r = (ri == 0) ? 16'h0000 : (ri == 1) ? 16'h1234 : (ri == 2) ? 16'hFFF0 : 16'hFFFF;
          set16(A_CAP_LO, r);
          set16(A_CNT_LO, 16'hFFFF - 16'(k));
          e = 16'hFFFF - 16'(k);
          ovfs = 0;
          for (int t = 0; t < k + 1 + m; t++) begin
            if (e == 16'hFFFF) ovfs++;
            e = step_rl(e, r);
          end
          wr(A_CTRL, C_RUN);
          run_ticks(k + 1 + m);
          settle();
          rd16(A_CNT_LO, v); chk("R4 reload on wrap", v, e);
          rd(A_CTRL, b);
          chk("R7 overflow flag", {8'h00, b}, (ovfs > 0) ? 16'h0084 : 16'h0004);
          wr(A_CTRL, 8'h00);
          rd(A_CTRL, b); chk("R10 software clear", {8'h00, b}, 16'h0000);
        end
      end
    end

    // R7: capture mode wraps to zero and still flags
    set16(A_CAP_LO, 16'h1111);
    set16(A_CNT_LO, 16'hFFFE);
    wr(A_CTRL, C_RUN | C_CAP);
    run_ticks(3);
    settle();
    rd16(A_CNT_LO, v); chk("R7 capture mode wraps", v, 16'h0001);
    rd(A_CTRL, b);     chk("R7 capture mode flag", {8'h00, b}, 16'h0085);
    wr(A_CTRL, 8'h00);

    // R8: baud ticks
    set16(A_CAP_LO, 16'hFFFC);
    set16(A_CNT_LO, 16'hFFFC);
    wr(A_CTRL, C_RUN | C_RX);
    base_rx = rx_seen; base_tx = tx_seen;
    run_ticks(20);
    settle();
    chk("R8 rx ticks", 16'(rx_seen - base_rx), 16'd5);
    chk("R8 tx quiet", 16'(tx_seen - base_tx), 16'd0);
    rd(A_CTRL, b);     chk("R8 no overflow flag", {8'h00, b}, 16'h0024);
    rd16(A_CNT_LO, v); chk("R8 reload rx", v, 16'hFFFC);
    wr(A_CTRL, C_RUN | C_TX | C_CAP);
    base_rx = rx_seen; base_tx = tx_seen;
    run_ticks(10);
    settle();
    chk("R8 tx ticks", 16'(tx_seen - base_tx), 16'd2);
    chk("R8 rx quiet", 16'(rx_seen - base_rx), 16'd0);
    rd16(A_CNT_LO, v); chk("R8 reload despite capture mode", v, 16'hFFFE);
    rd(A_CTRL, b);     chk("R8 no flag in tx mode", {8'h00, b}, 16'h0015);
    set16(A_CNT_LO, 16'hFFFC);
    wr(A_CTRL, C_RUN | C_TX | C_RX);
    base_rx = rx_seen; base_tx = tx_seen;
    run_ticks(8);
    settle();
    chk("R8 both rx", 16'(rx_seen - base_rx), 16'd2);
    chk("R8 both tx", 16'(tx_seen - base_tx), 16'd2);
    wr(A_CTRL, 8'h00);

    // R5: trigger reload
    set16(A_CAP_LO, 16'hABCD);
    set16(A_CNT_LO, 16'h0012);
    wr(A_CTRL, C_RUN);
    pulse_trig();
    rd16(A_CNT_LO, v); chk("R5 trigger disabled keeps count", v, 16'h0012);
    rd(A_CTRL, b);     chk("R5 trigger disabled no flag", {8'h00, b}, 16'h0004);
    wr(A_CTRL, C_RUN | C_EXEN);
    pulse_trig();
    rd16(A_CNT_LO, v); chk("R5 trigger reload", v, 16'hABCD);
    rd(A_CTRL, b);     chk("R5 trigger flag", {8'h00, b}, 16'h004C);
    wr(A_CTRL, 8'h00);

    // R6: capture
    set16(A_CAP_LO, 16'h0000);
    set16(A_CNT_LO, 16'h0777);
    wr(A_CTRL, C_RUN | C_EXEN | C_CAP);
    pulse_trig();
    rd16(A_CAP_LO, v); chk("R6 capture value", v, 16'h0777);
    rd16(A_CNT_LO, v); chk("R6 count kept", v, 16'h0777);
    rd(A_CTRL, b);     chk("R6 trigger flag", {8'h00, b}, 16'h004D);
    run_ticks(9);
    settle();
    rd16(A_CNT_LO, v); chk("R6 counting continues", v, 16'h0780);
    rd16(A_CAP_LO, v); chk("R6 pair holds", v, 16'h0777);
    @(negedge clk);
    tick_en = 1'b1; trig_pin = 1'b0;
    repeat (8) @(negedge clk);
    trig_pin = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b0;
    settle();
    rd16(A_CNT_LO, v); chk("R6 no pause during capture", v, 16'h078C);
    rd16(A_CAP_LO, v); chk("R6 capture while running", v, 16'h0782);
    wr(A_CTRL, 8'h00);

    // R9: interrupt combination sweep
    for (int f = 0; f < 4; f++) begin
      for (int ie = 0; ie < 2; ie++) begin
        for (int g = 0; g < 2; g++) begin
          wr(A_CTRL, 8'(f << 6));
          tmr_ie = 1'(ie); glb_ie = 1'(g);
          #1;
          chk("R9 interrupt", {15'd0, irq}, {15'd0, (f != 0) && ie == 1 && g == 1});
        end
      end
    end
    tmr_ie = 1'b0; glb_ie = 1'b0;
    wr(A_CTRL, 8'h00);

    // R10: hardware set beats software clear
    set16(A_CAP_LO, 16'h0000);
    set16(A_CNT_LO, 16'hFFFF);
    wr(A_CTRL, C_RUN | C_TF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = C_RUN; tick_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    settle();
    rd(A_CTRL, b);     chk("R10 set wins over clear", {8'h00, b}, 16'h0084);
    rd16(A_CNT_LO, v); chk("R10 wrap reload", v, 16'h0000);
    repeat (10) @(negedge clk);
    rd(A_CTRL, b);     chk("R10 flag sticky", {8'h00, b}, 16'h0084);
    wr(A_CTRL, C_RUN);

    // R11: count write beats wrap
    set16(A_CAP_LO, 16'h4321);
    set16(A_CNT_LO, 16'hFFFF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CNT_LO; reg_wdata = 8'h55; tick_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    settle();
    rd16(A_CNT_LO, v); chk("R11 write wins", v, 16'hFF55);
    rd(A_CTRL, b);     chk("R11 no overflow flag", {8'h00, b}, 16'h0004);
    wr(A_CTRL, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule